// File: doc/BRIEF.md
# Shift-Capable Integer ALU

This block is the arithmetic and logic unit of a small single-cycle processor core. It is purely combinational. It takes two operands `op_a` and `op_b`, a separate shift amount `shamt` and a 4-bit function code `fn`. It returns one result word `result` in the same evaluation in which its inputs change. There is no clock, no reset and no internal state.

The block provides seven operations: modulo addition and subtraction, bitwise OR, an upper-half immediate placement, and three shifts of `op_b` by `shamt`. The shifts are a zero-fill left shift, a zero-fill right shift and a sign-fill right shift. Overflow is ignored, so signed and unsigned forms of add and subtract are the same operation. The block raises no flags. Every unused function code gives an all-zero result.

The datapath width is the parameter `WIDTH` (default 32, a power of two). The shift-amount width is `$clog2(WIDTH)`. The upper-half operation moves `op_b` left by `WIDTH/2`, which is 16 at the default width.

Top module: `shift_alu`

## Requirements
- R1: With `fn` = 4'b0000, `result` equals (`op_a` + `op_b`) modulo 2^WIDTH, and a carry out has no effect.
- R2: With `fn` = 4'b0001, `result` equals (`op_a` − `op_b`) modulo 2^WIDTH, and a borrow wraps around.
- R3: With `fn` = 4'b0010, `result` equals the bitwise OR of `op_a` and `op_b`.
- R4: With `fn` = 4'b0011, `result` holds the lower WIDTH/2 bits of `op_b` in its upper half and zeros in its lower half, and `op_a` has no effect.
- R5: With `fn` = 4'b0100, `result` is `op_b` shifted left by `shamt` with zeros entering at bit 0, and `op_a` has no effect.
- R6: With `fn` = 4'b0101, `result` is `op_b` shifted right by `shamt` with zeros entering at the most significant bit, and `op_a` has no effect.
- R7: With `fn` = 4'b0110, `result` is `op_b` shifted right by `shamt` with copies of `op_b`'s most significant bit entering at the top, and `op_a` has no effect.
- R8: Any `fn` from 4'b0111 to 4'b1111 drives `result` to all zeros, whatever the operands and shift amount are.
- R9: `result` depends only on the present inputs. It follows an input change with no clock edge, and all-zero inputs give an all-zero result.
- R10: `shamt` has no effect on `result` for the function codes 4'b0000 to 4'b0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand. Used by add, subtract and OR. |
| op_b | input | WIDTH | Second operand. It is also the source for the upper-half operation and the shifts. |
| shamt | input | $clog2(WIDTH) | Shift distance for the three shift codes. |
| fn | input | 4 | Function code, see R1 to R8. |
| result | output | WIDTH | Combinational result. |

## Verification
The bench builds the block twice. One copy uses the default `WIDTH` = 32. The other uses `WIDTH` = 8, with a 3-bit shift amount.

The 8-bit copy makes exhaustive sweeps practical. Add, subtract and OR are checked for every operand pair, including every carry and borrow wrap. Each shift is checked for every `op_b` value at every shift distance. The upper-half operation is checked for every `op_b`.

The 32-bit copy is driven with pseudo-random operands across all sixteen function codes. It also gets directed corner values: the largest positive value plus one, zero minus one, a sign-fill shift by the maximum distance, and shifts by zero.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

    localparam int unsigned FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ADD   = 4'd0,
        FN_SUB   = 4'd1,
        FN_OR    = 4'd2,
        FN_UPPER = 4'd3,
        FN_SHL   = 4'd4,
        FN_SHR   = 4'd5,
        FN_SAR   = 4'd6
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_LEFT   = 2'd0,
        SH_RLOG   = 2'd1,
        SH_RARITH = 2'd2,
        SH_IDLE   = 2'd3
    } shift_mode_e;

endpackage

// File: rtl/shift_alu_addsub.sv
module shift_alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             subtract,
    output logic [WIDTH-1:0] result
);

    logic [WIDTH-1:0] b_eff_d;
    logic [WIDTH-1:0] cin_d;

    // Two's complement subtraction: invert B and inject a carry of one.
    always_comb begin
        b_eff_d = op_b ^ {WIDTH{subtract}};
        cin_d   = {{(WIDTH-1){1'b0}}, subtract};
        result  = op_a + b_eff_d + cin_d;
    end

endmodule

// File: rtl/shift_alu_bitwise.sv
module shift_alu_bitwise #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] or_out,
    output logic [WIDTH-1:0] upper_out
);

    localparam int unsigned HALF = WIDTH / 2;

    always_comb begin
        or_out    = op_a | op_b;
        upper_out = op_b << HALF;
    end

endmodule

// File: rtl/shift_alu_shifter.sv
module shift_alu_shifter
    import shift_alu_pkg::*;
#(
    parameter  int unsigned WIDTH = 32,
    localparam int unsigned SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src,
    input  logic [SHW-1:0]   amount,
    input  shift_mode_e      mode,
    output logic [WIDTH-1:0] result
);

    function automatic logic [WIDTH-1:0] bit_reverse(input logic [WIDTH-1:0] v);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < int'(WIDTH); i++) begin
            r[i] = v[WIDTH-1-i];
        end
        return r;
    endfunction

    logic                      go_left;
    logic                      fill_bit;
    logic [SHW:0][WIDTH-1:0]   stage;

    // A left shift reuses the right-shift stages on a bit-reversed word.
    assign go_left  = (mode == SH_LEFT);
    assign fill_bit = (mode == SH_RARITH) & src[WIDTH-1];
    assign stage[0] = go_left ? bit_reverse(src) : src;

    // One stage per shift-amount bit; stage k moves by 2**k.
    for (genvar k = 0; k < int'(SHW); k++) begin : g_stage
        localparam int unsigned DIST = 2 ** k;
        assign stage[k+1] = amount[k]
            ? {{DIST{fill_bit}}, stage[k][WIDTH-1:DIST]}
            : stage[k];
    end

    assign result = go_left ? bit_reverse(stage[SHW]) : stage[SHW];

endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import shift_alu_pkg::*;
#(
    parameter  int unsigned WIDTH = 32,
    localparam int unsigned SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [SHW-1:0]   shamt,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] result
);

    typedef struct packed {
        logic [WIDTH-1:0] arith;
        logic [WIDTH-1:0] bit_or;
        logic [WIDTH-1:0] upper;
        logic [WIDTH-1:0] shifted;
    } lanes_t;

    lanes_t           lanes_d;
    logic             subtract_d;
    shift_mode_e      mode_d;
    logic [WIDTH-1:0] result_d;

    // Lane controls decoded from the function code.
    always_comb begin
        subtract_d = (fn == FN_SUB);
        case (fn)
            FN_SHL:  mode_d = SH_LEFT;
            FN_SHR:  mode_d = SH_RLOG;
            FN_SAR:  mode_d = SH_RARITH;
            default: mode_d = SH_IDLE;
        endcase
    end

    shift_alu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .op_a     (op_a),
        .op_b     (op_b),
        .subtract (subtract_d),
        .result   (lanes_d.arith)
    );

    shift_alu_bitwise #(.WIDTH(WIDTH)) i_bitwise (
        .op_a      (op_a),
        .op_b      (op_b),
        .or_out    (lanes_d.bit_or),
        .upper_out (lanes_d.upper)
    );

    shift_alu_shifter #(.WIDTH(WIDTH)) i_shifter (
        .src    (op_b),
        .amount (shamt),
        .mode   (mode_d),
        .result (lanes_d.shifted)
    );

    // Output select; unassigned codes collapse to zero.
    always_comb begin
        case (fn)
            FN_ADD, FN_SUB:         result_d = lanes_d.arith;
            FN_OR:                  result_d = lanes_d.bit_or;
            FN_UPPER:               result_d = lanes_d.upper;
            FN_SHL, FN_SHR, FN_SAR: result_d = lanes_d.shifted;
            default:                result_d = '0;
        endcase
    end

    assign result = result_d;

endmodule

// File: rtl/shift_alu_chk.sv
module shift_alu_chk #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SHW   = 5
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [SHW-1:0]   shamt,
    input logic [3:0]       fn,
    input logic [WIDTH-1:0] result
);

    localparam int unsigned HALF = WIDTH / 2;

    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;

    assign low_mask  = ~({WIDTH{1'b1}} << shamt);
    assign high_mask = ~({WIDTH{1'b1}} >> shamt);

    always_comb begin
        if (fn == 4'd0) begin
            p_add_inverse_r1: assert (result - op_b == op_a);
        end
        if (fn == 4'd1) begin
            p_sub_inverse_r2: assert (result + op_b == op_a);
        end
        if (fn == 4'd2) begin
            p_or_covers_r3: assert (((result & op_a) == op_a) && ((result & op_b) == op_b)
                                    && ((result & ~(op_a | op_b)) == '0));
        end
        if (fn == 4'd3) begin
            p_upper_place_r4: assert ((result[HALF-1:0] == '0)
                                      && (result[WIDTH-1:HALF] == op_b[HALF-1:0]));
        end
        if (fn == 4'd4) begin
            p_shl_low_zero_r5: assert ((result & low_mask) == '0);
        end
        if (fn == 4'd5) begin
            p_shr_high_zero_r6: assert ((result & high_mask) == '0);
        end
        if (fn == 4'd6) begin
            p_sar_sign_kept_r7: assert (result[WIDTH-1] == op_b[WIDTH-1]);
        end
        if (fn >= 4'd7) begin
            p_unused_zero_r8: assert (result == '0);
        end
    end

endmodule

bind shift_alu shift_alu_chk #(.WIDTH(WIDTH), .SHW(SHW)) i_chk (.*);

// File: tb/test_shift_alu.sv
module test_shift_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] a32 = '0, b32 = '0, r32;
    logic [4:0]  sh32 = '0;
    logic [3:0]  fn32 = '0;

    logic [7:0]  a8 = '0, b8 = '0, r8;
    logic [2:0]  sh8 = '0;
    logic [3:0]  fn8 = '0;

    shift_alu i_shift_alu (
        .op_a(a32), .op_b(b32), .shamt(sh32), .fn(fn32), .result(r32)
    );

    shift_alu #(.WIDTH(8)) i_shift_alu_w8 (
        .op_a(a8), .op_b(b8), .shamt(sh8), .fn(fn8), .result(r8)
    );

    // Independent reference model for any width up to 32.
    function automatic logic [31:0] ref_model(int w, logic [3:0] f, logic [31:0] a,
                                              logic [31:0] b, int sh);
        logic [63:0] mask, aa, bb, v;
        logic signed [63:0] sb;
        mask = (64'd1 << w) - 64'd1;
        aa = {32'd0, a} & mask;
        bb = {32'd0, b} & mask;
        sb = bb[w-1] ? signed'(bb | ~mask) : signed'(bb);
        case (f)
            4'd0: v = aa + bb;
            4'd1: v = aa - bb;
            4'd2: v = aa | bb;
            4'd3: v = bb << (w / 2);
            4'd4: v = bb << sh;
            4'd5: v = bb >> sh;
            4'd6: v = 64'(sb >>> sh);
            default: v = 64'd0;
        endcase
        v = v & mask;
        return v[31:0];
    endfunction

    function automatic string req_of(logic [3:0] f);
        case (f)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run32(logic [3:0] f, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
        fn32 = f; a32 = a; b32 = b; sh32 = sh;
        #1;
        check(req_of(f), r32, ref_model(32, f, a, b, int'(sh)));
    endtask

    task automatic run8(logic [3:0] f, logic [7:0] a, logic [7:0] b, logic [2:0] sh,
                        string req);
        fn8 = f; a8 = a; b8 = b; sh8 = sh;
        #1;
        check(req, {24'd0, r8}, ref_model(8, f, {24'd0, a}, {24'd0, b}, int'(sh)));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] x, y;
        #2;
        // R9: all-zero inputs give zero without any clock edge.
        check("R9", r32, 32'd0);
        check("R9", {24'd0, r8}, 32'd0);

        // Exhaustive 8-bit add, subtract and OR: R1, R2, R3.
        for (int f = 0; f < 3; f++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    run8(4'(f), 8'(a), 8'(b), 3'(a), req_of(4'(f)));

        // Exhaustive 8-bit upper placement with A varied: R4.
        for (int b = 0; b < 256; b++) begin
            run8(4'd3, 8'h00, 8'(b), 3'(b), "R4");
            run8(4'd3, 8'hFF, 8'(b), 3'(b), "R4");
        end

        // Every B at every distance for each shift, A varied: R5, R6, R7.
        for (int f = 4; f < 7; f++)
            for (int b = 0; b < 256; b++)
                for (int s = 0; s < 8; s++) begin
                    run8(4'(f), 8'h00, 8'(b), 3'(s), req_of(4'(f)));
                    run8(4'(f), 8'hA5, 8'(b), 3'(s), req_of(4'(f)));
                end

        // Unused codes return zero: R8.
        for (int f = 7; f < 16; f++)
            for (int v = 0; v < 256; v += 7)
                run8(4'(f), 8'(v), 8'(255 - v), 3'(v), "R8");

        // Shift amount ignored on non-shift codes: R10.
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < 8; s++)
                run8(4'(f), 8'h3C, 8'hA7, 3'(s), "R10");

        // 32-bit directed corners.
        run32(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);   // R1 signed wrap
        run32(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);   // R1 carry dropped
        run32(4'd1, 32'h0000_0000, 32'h0000_0001, 5'd0);   // R2 borrow wrap
        run32(4'd1, 32'h8000_0000, 32'h0000_0001, 5'd0);   // R2
        run32(4'd3, 32'hDEAD_BEEF, 32'h1234_ABCD, 5'd7);   // R4
        run32(4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 5'd31);  // R5
        run32(4'd5, 32'h0, 32'h8000_0000, 5'd31);          // R6
        run32(4'd6, 32'h0, 32'h8000_0000, 5'd31);          // R7
        run32(4'd6, 32'h0, 32'h8765_4321, 5'd0);           // R7 zero distance
        run32(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31); // R8

        // R9: result follows an operand change with no clock edge.
        fn32 = 4'd0; a32 = 32'd10; b32 = 32'd5; #1;
        check("R9", r32, 32'd15);
        b32 = 32'd20; #1;
        check("R9", r32, 32'd30);

        // 32-bit pseudo-random sweep over all codes.
        x = 32'h1234_5678;
        y = 32'h9ABC_DEF1;
        for (int i = 0; i < 2000; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            y ^= y << 13; y ^= y >> 17; y ^= y << 5;
            for (int f = 0; f < 16; f++)
                run32(4'(f), x, y, y[4:0] ^ x[9:5]);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule